// File: doc/BRIEF.md
# Converter Clock Control and Result Formatter

This block holds one 8-bit control byte for an on-chip analog-to-digital converter and acts on its three fields. The first field picks the timebase: either every bus clock cycle, or every rising edge of a slower external oscillator clock. The second field picks a power-of-two division of that timebase, which yields a single-cycle converter clock enable. The third field picks how a raw 10-bit conversion code is laid out across two data bytes.

All logic runs on the bus clock. The oscillator clock is synchronised and edge-detected, so the converter clock enable is a qualified pulse in the bus domain and not a second clock. Software writes the control byte through a simple write strobe and reads it back at any time. The converter model presents a raw code together with a one-cycle done strobe, and the formatted bytes are captured on that strobe.

Top module: `adc_clkfmt_top`

## Requirements
- R1: After synchronous active-low reset, the control byte reads 0x04 (divide-by-1, external oscillator source, right-justified mode) and both data bytes read 0x00.
- R2: A write stores data bits 7:2 into the control byte. Control bits 1:0 always read 0, whatever value is written to them.
- R3: Control bits 7:5 select the divide ratio N of the prescaler input ticks: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and any value 1xx gives 16. The enable is high for one bus cycle once every N ticks.
- R4: Control bit 4 selects the tick source. A value of 1 gives one tick on every bus clock cycle. A value of 0 gives one tick per rising edge of the oscillator clock, which is seen three bus cycles after the edge. The oscillator must run below half the bus clock rate.
- R5: Any write to the control byte restarts the prescaler count at zero. With the bus source selected, the first enable after a write appears N-1 cycles after the write edge, or in the cycle right after the write edge when N is 1.
- R6: Mode 00 (control bits 3:2) truncates. The low byte gets code bits 9:2 and the high byte is 0.
- R7: Mode 01 right-justifies. The high byte is {6'b0, code[9:8]} and the low byte is code[7:0].
- R8: Mode 10 left-justifies. The high byte is code[9:2] and the low byte is {code[1:0], 6'b0}.
- R9: Mode 11 left-justifies as signed. The layout is the same as mode 10, with code bit 9 inverted, so the offset code becomes two's complement.
- R10: The data bytes change only in the cycle after a done strobe, using the mode in force at that strobe. A later mode change leaves them unchanged until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is clocked here |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_clk | input | 1 | External oscillator clock, sampled as data |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte readback |
| raw_code | input | 10 | Raw conversion code from the converter |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_clk_en | output | 1 | Divided converter clock enable pulse |
| data_hi | output | 8 | Formatted high data byte |
| data_lo | output | 8 | Formatted low data byte |

## Verification
Every one of the eight divider codes is run with each tick source. The spacing between pulses is measured, so the four 1xx aliases can be told apart from the lower encodings, and oscillator-paced timing can be told apart from bus-paced timing. The gap from a write to the first pulse shows whether the count restarts. The codes 0x000, 0x3FF, 0x200, 0x1FF, 0x2A5 and 0x15A are formatted in all four modes. The all-ones and alternating patterns expose swapped or shifted bits. The 0x1FF/0x200 pair checks the sign inversion at the midscale boundary. A mode change with no strobe shows that captured bytes hold.

// File: rtl/adcfmt_pkg.sv
// Package: shared widths, control-byte field positions and helpers for the
// converter clock control and result formatter. Assumes an 8-bit control
// byte and a raw code wider than one byte but no wider than two.
package adcfmt_pkg;
    parameter int BYTE_W      = 8;
    parameter int CODE_W      = 10;
    parameter int DSEL_W      = 3;
    parameter int SYNC_STAGES = 2;

    localparam int MAX_EXP = 1 << (DSEL_W - 1);   // largest divide is 2**MAX_EXP
    localparam int CNT_W   = MAX_EXP;              // counter reaches 2**MAX_EXP-1
    localparam int PAD_W   = 2 * BYTE_W - CODE_W;

    localparam int DSEL_HI = 7;
    localparam int DSEL_LO = 5;
    localparam int SRC_BIT = 4;
    localparam int MODE_HI = 3;
    localparam int MODE_LO = 2;

    localparam logic [BYTE_W-1:0] CTL_RESET = 8'h04;
    localparam logic [BYTE_W-1:0] CTL_WMASK = 8'hFC;

    typedef enum logic [1:0] {
        FMT_TRUNC  = 2'b00,
        FMT_RIGHT  = 2'b01,
        FMT_LEFT   = 2'b10,
        FMT_SIGNED = 2'b11
    } fmt_mode_e;

    // Terminal count (N-1) for a divider select code.
    function automatic logic [CNT_W-1:0] div_last(input logic [DSEL_W-1:0] sel);
        int n;
        if (sel[DSEL_W-1])
            n = 1 << MAX_EXP;
        else
            n = 1 << sel[DSEL_W-2:0];
        return CNT_W'(n - 1);
    endfunction
endpackage

// File: rtl/adcclk_ctl_reg.sv
// Control byte storage. Holds the divider select, tick source and format
// mode. Assumes writes are whole-byte; unimplemented low bits are masked.
module adcclk_ctl_reg
    import adcfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ctl_q
);
    // Capture a write, keeping only the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= CTL_RESET;
        else if (wr_en)
            ctl_q <= wr_data & CTL_WMASK;
    end

    // R2: implemented bits follow the written value one cycle later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctl_q[BYTE_W-1:MODE_LO] == $past(wr_data[BYTE_W-1:MODE_LO]));
    // R2: unimplemented bits never hold a one
    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctl_q[MODE_LO-1:0] == '0);
endmodule

// File: rtl/adcclk_src_tick.sv
// Tick source selection. Synchronises the oscillator clock into the bus
// domain and turns each rising edge into a one-cycle tick, or ticks on
// every cycle when the bus source is chosen. Assumes the oscillator runs
// below half the bus rate so that no edge is missed.
module adcclk_src_tick
    import adcfmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_clk,
    input  logic use_bus,
    output logic tick
);
    logic [SYNC_STAGES:0] osc_sh;
    logic                 osc_rise;

    // Shift the oscillator level through the synchroniser and edge flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            osc_sh <= '0;
        else
            osc_sh <= {osc_sh[SYNC_STAGES-1:0], osc_clk};
    end

    // Detect a fresh high level after the synchroniser stages.
    always_comb osc_rise = osc_sh[SYNC_STAGES-1] & ~osc_sh[SYNC_STAGES];

    // Pick the tick source.
    always_comb tick = use_bus ? 1'b1 : osc_rise;

    // R4: bus source ticks on every cycle
    a_r4_bus_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        use_bus |-> tick);
    // R4: oscillator ticks are isolated single cycles
    a_r4_osc_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_bus && tick) |=> (!tick || $past(use_bus) != use_bus || use_bus));
endmodule

// File: rtl/adcclk_prescaler.sv
// Power-of-two prescaler. Counts input ticks and pulses its enable on the
// tick that reaches the terminal count. A restart forces the count to zero.
// Assumes the terminal count changes only together with a restart.
module adcclk_prescaler
    import adcfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] last,
    output logic             en
);
    logic [CNT_W-1:0] cnt;

    // Advance on ticks, wrap at terminal count, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end

    // Pulse on the tick that completes a period.
    always_comb en = tick && (cnt == last);

    // R5: a write leaves the count at zero
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt == '0);
    // R3: the count never passes the terminal value
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);
    // R3: an enable always coincides with an input tick
    a_r3_en_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> tick);
endmodule

// File: rtl/adc_result_fmt.sv
// Result formatter. On the done strobe, places the raw code across the
// high and low data bytes according to the mode in force, then holds.
// Assumes the code is wider than a byte and no wider than two.
module adc_result_fmt
    import adcfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  fmt_mode_e         mode,
    input  logic [CODE_W-1:0] code,
    output logic [BYTE_W-1:0] data_hi,
    output logic [BYTE_W-1:0] data_lo
);
    logic [2*BYTE_W-1:0] word;

    // Lay out the code for the selected mode.
    always_comb begin
        case (mode)
            FMT_TRUNC:  word = {{BYTE_W{1'b0}}, code[CODE_W-1 -: BYTE_W]};
            FMT_RIGHT:  word = {{PAD_W{1'b0}}, code};
            FMT_LEFT:   word = {code, {PAD_W{1'b0}}};
            default:    word = {~code[CODE_W-1], code[CODE_W-2:0], {PAD_W{1'b0}}};
        endcase
    end

    // Capture the formatted word only on a completed conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_hi <= '0;
            data_lo <= '0;
        end else if (done) begin
            data_hi <= word[2*BYTE_W-1:BYTE_W];
            data_lo <= word[BYTE_W-1:0];
        end
    end

    // R10: bytes hold when no conversion completes
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(data_hi) && $stable(data_lo)));
    // R9: signed mode flips the top code bit into the sign position
    a_r9_sign_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode == FMT_SIGNED) |=> data_hi[BYTE_W-1] == !$past(code[CODE_W-1]));
    // R6: truncation always clears the high byte
    a_r6_trunc_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode == FMT_TRUNC) |=> data_hi == '0);
endmodule

// File: rtl/adc_clkfmt_top.sv
// Top of the converter clock control and result formatter. Ties the
// control byte to the tick source, the prescaler and the formatter.
// Assumes a single bus clock; the oscillator is treated as sampled data.
module adc_clkfmt_top
    import adcfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_clk,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [CODE_W-1:0] raw_code,
    input  logic              conv_done,
    output logic              conv_clk_en,
    output logic [BYTE_W-1:0] data_hi,
    output logic [BYTE_W-1:0] data_lo
);
    logic [BYTE_W-1:0] ctl_q;
    logic              tick;
    logic [CNT_W-1:0]  last;
    fmt_mode_e         mode;

    adcclk_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl_q)
    );

    // Decode the control fields.
    always_comb begin
        last    = div_last(ctl_q[DSEL_HI:DSEL_LO]);
        mode    = fmt_mode_e'(ctl_q[MODE_HI:MODE_LO]);
        rd_data = ctl_q;
    end

    adcclk_src_tick u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_clk (osc_clk),
        .use_bus (ctl_q[SRC_BIT]),
        .tick    (tick)
    );

    adcclk_prescaler u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (wr_en),
        .last    (last),
        .en      (conv_clk_en)
    );

    adc_result_fmt u_fmt (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (conv_done),
        .mode    (mode),
        .code    (raw_code),
        .data_hi (data_hi),
        .data_lo (data_lo)
    );

    // R1: reset leaves the documented control value
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> rd_data == CTL_RESET);
endmodule

// File: tb/adc_clkfmt_top_tb.sv
module adc_clkfmt_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OSC_HALF   = 3;   // bus cycles per oscillator half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [9:0] raw_code = 10'h000;
    logic       conv_done = 1'b0;
    logic [7:0] rd_data;
    logic       conv_clk_en;
    logic [7:0] data_hi;
    logic [7:0] data_lo;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    adc_clkfmt_top u_dut (
        .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .raw_code(raw_code), .conv_done(conv_done),
        .conv_clk_en(conv_clk_en), .data_hi(data_hi), .data_lo(data_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Oscillator: toggles on falling bus edges, period 2*OSC_HALF cycles.
    initial begin
        forever begin
            repeat (OSC_HALF) @(negedge clk);
            osc_clk = ~osc_clk;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    int m_ctl = 8'h04, m_cnt = 0, m_hi = 0, m_lo = 0;
    int oq[$] = '{0, 0, 0};   // oscillator samples, newest first
    bit m_valid = 0;

    function automatic int div_of(int c);
        if (c & 8'h80) return 16;
        return 1 << ((c >> 5) & 3);
    endfunction

    function automatic int fmt_word(int mode, int code);
        case (mode)
            0: return (code >> 2) & 8'hFF;
            1: return code;
            2: return (code << 6) & 16'hFFFF;
            default: return ((code ^ 10'h200) << 6) & 16'hFFFF;
        endcase
    endfunction

    function automatic bit m_tick();
        if (m_ctl & 8'h10) return 1;
        return (oq[1] != 0) && (oq[2] == 0);
    endfunction

    always @(posedge clk) begin
        bit t;
        int w;
        t = m_tick();
        if (!rst_n) begin
            m_ctl = 8'h04; m_cnt = 0; m_hi = 0; m_lo = 0;
            oq = '{0, 0, 0};
            m_valid = 1;
        end else begin
            if (conv_done) begin
                w = fmt_word((m_ctl >> 2) & 3, raw_code);
                m_hi = (w >> 8) & 8'hFF;
                m_lo = w & 8'hFF;
            end
            if (wr_en) begin
                m_cnt = 0;
                m_ctl = wr_data & 8'hFC;
            end else if (t) begin
                m_cnt = (m_cnt + 1) % div_of(m_ctl);
            end
            void'(oq.pop_back());
            oq.push_front(int'(osc_clk));
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        bit e;
        if (m_valid) begin
            e = m_tick() && (m_cnt == div_of(m_ctl) - 1);
            chk(conv_clk_en == e, "R3/R4 enable", conv_clk_en, e);
            chk(rd_data == m_ctl[7:0], "R2 readback", rd_data, m_ctl);
            chk(data_hi == m_hi[7:0], "R10 data_hi", data_hi, m_hi);
            chk(data_lo == m_lo[7:0], "R10 data_lo", data_lo, m_lo);
        end
    end

    task automatic write_ctl(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic convert(input logic [9:0] c);
        conv_done = 1'b1; raw_code = c;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Wait for the next enable pulse; returns the cycles waited.
    task automatic next_pulse(output int k);
        k = 0;
        while (!conv_clk_en) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        int k, sp, mode, w;
        int codes[6] = '{10'h000, 10'h3FF, 10'h200, 10'h1FF, 10'h2A5, 10'h15A};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rd_data == 8'h04, "R1 reset ctl", rd_data, 8'h04);
        chk(data_hi == 8'h00 && data_lo == 8'h00, "R1 reset data", {data_hi, data_lo}, 0);

        // R2: low bits ignored
        write_ctl(8'hFF);
        chk(rd_data == 8'hFC, "R2 masked write", rd_data, 8'hFC);
        write_ctl(8'h03);
        chk(rd_data == 8'h00, "R2 low bits only", rd_data, 8'h00);

        // R3/R4/R5: every divider code with both sources
        for (int src = 1; src >= 0; src--) begin
            for (int sel = 0; sel < 8; sel++) begin
                int n;
                n = (sel >= 4) ? 16 : (1 << sel);
                write_ctl(8'((sel << 5) | (src << 4) | 8'h04));
                next_pulse(k);
                if (src == 1)
                    chk(k == n - 1, "R5 first pulse after write", k, n - 1);
                @(negedge clk);
                next_pulse(sp);
                sp++;
                chk(sp == n * (src ? 1 : 2 * OSC_HALF),
                    src ? "R3 spacing bus source" : "R4 spacing osc source",
                    sp, n * (src ? 1 : 2 * OSC_HALF));
            end
        end

        // R6..R9: every mode with several code patterns
        for (mode = 0; mode < 4; mode++) begin
            write_ctl(8'(8'h10 | (mode << 2)));
            foreach (codes[i]) begin
                convert(10'(codes[i]));
                w = fmt_word(mode, codes[i]);
                case (mode)
                    0: chk({data_hi, data_lo} == 16'(w), "R6 truncation", {data_hi, data_lo}, w);
                    1: chk({data_hi, data_lo} == 16'(w), "R7 right justify", {data_hi, data_lo}, w);
                    2: chk({data_hi, data_lo} == 16'(w), "R8 left justify", {data_hi, data_lo}, w);
                    default: chk({data_hi, data_lo} == 16'(w), "R9 signed", {data_hi, data_lo}, w);
                endcase
            end
        end

        // R10: mode change without a strobe reformats nothing
        write_ctl(8'h14);
        convert(10'h2A5);
        chk({data_hi, data_lo} == 16'h02A5, "R10 captured", {data_hi, data_lo}, 16'h02A5);
        write_ctl(8'h1C);
        raw_code = 10'h0F0;
        repeat (3) @(negedge clk);
        chk({data_hi, data_lo} == 16'h02A5, "R10 hold after mode change",
            {data_hi, data_lo}, 16'h02A5);
        convert(10'h0F0);
        chk({data_hi, data_lo} == 16'hBC00, "R10 new mode on strobe",
            {data_hi, data_lo}, 16'hBC00);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule